// File: doc/BRIEF.md
# Write-Through Word Cache

This block is a direct-mapped, write-through cache that holds 4 KB of data as 1024 lines of one 32-bit word each. It sits between a processor's load/store port and a slower memory port. Only two adjacent 1 MB address regions can be cached. Any access outside them goes straight to memory and leaves the cache unchanged.

Loads return a byte, a halfword or a word. The value is zero-extended, and the lane is chosen from the low address bits, with an optional big-endian lane swap. Every store is forwarded to memory. A full-word store to a cacheable address also writes the line. A halfword or byte store to a cacheable address invalidates the line instead of merging into it.

The processor side uses a valid/ready request channel. `req_ready` is high only when the cache is idle, so a request waits while any memory transaction is open. The response is a single-cycle `rsp_valid` pulse with no back-pressure: the requester must be able to take it. The memory side is also valid/ready. The cache holds `mem_valid` and every request field steady until `mem_ready`. For a read, the cache takes `mem_rdata` in the same cycle that `mem_ready` is high.

Top module: `wt_word_cache`

## Requirements
- R1: Reset leaves all 1024 lines invalid, `req_ready` high, and both `rsp_valid` and `mem_valid` low. The first read of any cacheable address after reset goes to memory.
- R2: An address is cacheable only when bits [31:20] are 0x100 or 0x101. Any other read goes to memory every time, and its result is still lane-selected from the returned word.
- R3: The line index is address bits [11:2] and the stored tag is bits [20:12]. Two cacheable addresses with the same index and different tags evict each other.
- R4: A cacheable read miss issues a memory read with size code 2'b10 at the word-aligned address (low two bits zero). The returned word fills the line. The response appears one cycle after `mem_ready`.
- R5: A cacheable read hit raises `rsp_valid` one cycle after the request is accepted, makes no memory request, and keeps `req_ready` high so hits can issue back to back.
- R6: Every store reaches memory with its own address, size code and data, whether it hits, misses or is uncacheable. Its response pulse follows `mem_ready` by one cycle.
- R7: A cacheable full-word store writes both tag and data, even on a miss. A later read of that word hits and returns the stored value.
- R8: A cacheable byte or halfword store invalidates its line, so the next read of that word misses and returns the memory contents.
- R9: Size codes are 2'b00 byte, 2'b01 halfword, and 2'b10 or 2'b11 word. With `big_endian` low, a byte comes from bits [8*a+7 : 8*a] with a = addr[1:0]. A halfword comes from bits [16*addr[1]+15 : 16*addr[1]]. The upper bits of the result are zero.
- R10: With `big_endian` high, the low two address bits are XORed with 3 before the lane is chosen.
- R11: A real tag of all ones (addresses 0x101FFxxx) is cached and hits like any other tag.
- R12: From acceptance of a request that goes to memory until the cycle after `mem_ready`, `req_ready` is low. `mem_valid`, `mem_addr`, `mem_size` and `mem_write` stay stable until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Lane swap mode for sub-word reads |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, sub-word values in the low bits |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Zero-extended load data (zero for stores) |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_write | output | 1 | Memory request is a store |
| mem_size | output | 2 | Memory access size code |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory store data |
| mem_rdata | input | 32 | Aligned word returned for a read |

## Verification
A corrupted tag, data word or valid bit becomes visible at the ports on the next read of the affected index. A false hit returns stale data one cycle after acceptance with no memory request. A false miss shows up as an unexpected memory read and a longer response. A stuck or wrong controller state shows as `req_ready` staying low or a response pulse that never comes. The bench counts memory handshakes per access, so hit-versus-miss errors show up even when the data happens to match. It also reads back every line it has touched after stores of each size.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic {ST_IDLE, ST_MEM} wtc_state_e;

  // Zero-extended lane extraction from a 32-bit word.
  function automatic logic [31:0] lane_pick(input logic [31:0] w,
                                            input logic [1:0]  ofs,
                                            input logic [1:0]  sz,
                                            input logic        be);
    logic [1:0] o;
    o = ofs ^ {be, be};
    case (sz)
      SZ_BYTE: lane_pick = {24'b0, w[{o, 3'b000} +: 8]};
      SZ_HALF: lane_pick = {16'b0, w[{o[1], 4'b0000} +: 16]};
      default: lane_pick = w;
    endcase
  endfunction

endpackage

// File: rtl/wtc_addr_decode.sv
module wtc_addr_decode #(
  parameter int          INDEX_W     = 10,
  parameter int          TAG_W       = 9,
  parameter logic [11:0] WINDOW_BASE = 12'h100
) (
  input  logic [31:2]        word_addr,
  output logic               cacheable,
  output logic [INDEX_W-1:0] index,
  output logic [TAG_W-1:0]   tag
);
  localparam int TAG_LSB = 2 + INDEX_W;

  always_comb begin
    cacheable = (word_addr[31:20] == WINDOW_BASE) ||
                (word_addr[31:20] == WINDOW_BASE + 12'd1);
    index     = word_addr[2 +: INDEX_W];
    tag       = word_addr[TAG_LSB +: TAG_W];
  end
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [31:0]        rd_data,
  input  logic               wr_en,
  input  logic               inv_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [31:0]        wr_data
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem  [LINES];
  logic [31:0]      data_mem [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end else if (inv_en) begin
      valid_q[wr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    rd_valid = valid_q[rd_idx];
    rd_tag   = tag_mem[rd_idx];
    rd_data  = data_mem[rd_idx];
  end
endmodule

// File: rtl/wt_word_cache.sv
module wt_word_cache #(
  parameter int          INDEX_W     = 10,
  parameter int          TAG_W       = 9,
  parameter logic [11:0] WINDOW_BASE = 12'h100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_endian,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  import wtc_pkg::*;

  wtc_state_e state_q;

  // request held while memory is busy
  logic        h_write;
  logic [1:0]  h_size;
  logic [31:0] h_addr;
  logic [31:0] h_wdata;

  logic               req_cache, h_cache;
  logic [INDEX_W-1:0] req_idx, h_idx;
  logic [TAG_W-1:0]   req_tag, h_tag;

  logic               line_valid;
  logic [TAG_W-1:0]   line_tag;
  logic [31:0]        line_data;

  logic accept, hit, mem_done, fill_en, inv_en;

  wtc_addr_decode #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .WINDOW_BASE(WINDOW_BASE)) u_dec_req (
    .word_addr (req_addr[31:2]),
    .cacheable (req_cache),
    .index     (req_idx),
    .tag       (req_tag)
  );

  wtc_addr_decode #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .WINDOW_BASE(WINDOW_BASE)) u_dec_hold (
    .word_addr (h_addr[31:2]),
    .cacheable (h_cache),
    .index     (h_idx),
    .tag       (h_tag)
  );

  wtc_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_data  (line_data),
    .wr_en    (fill_en),
    .inv_en   (inv_en),
    .wr_idx   (h_idx),
    .wr_tag   (h_tag),
    .wr_data  (h_write ? h_wdata : mem_rdata)
  );

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    accept    = req_valid && req_ready;
    hit       = !req_write && req_cache && line_valid && (line_tag == req_tag);
    mem_done  = (state_q == ST_MEM) && mem_ready;
    // reads fill, full-word stores (size[1] set) write, sub-word stores invalidate
    fill_en   = mem_done && h_cache && (!h_write || h_size[1]);
    inv_en    = mem_done && h_cache && h_write && !h_size[1];

    mem_valid = (state_q == ST_MEM);
    mem_write = h_write;
    mem_size  = h_write ? h_size : SZ_WORD;
    mem_addr  = h_write ? h_addr : {h_addr[31:2], 2'b00};
    mem_wdata = h_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      h_write   <= 1'b0;
      h_size    <= SZ_WORD;
      h_addr    <= '0;
      h_wdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= lane_pick(line_data, req_addr[1:0], req_size, big_endian);
            end else begin
              state_q <= ST_MEM;
              h_write <= req_write;
              h_size  <= req_size;
              h_addr  <= req_addr;
              h_wdata <= req_wdata;
            end
          end
        end
        ST_MEM: begin
          if (mem_ready) begin
            state_q   <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= h_write ? 32'b0
                                 : lane_pick(mem_rdata, h_addr[1:0], h_size, big_endian);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter logic [11:0] WINDOW_BASE = 12'h100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [1:0]  mem_size,
  input logic [31:0] mem_addr
);
  logic in_window;
  assign in_window = (req_addr[31:20] == WINDOW_BASE) ||
                     (req_addr[31:20] == WINDOW_BASE + 12'd1);

  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_size) && $stable(mem_write));

  assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |-> (mem_addr[1:0] == 2'b00) && (mem_size == 2'b10));

  assert_ack_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> rsp_valid && !mem_valid);

  assert_store_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> mem_valid && mem_write && !req_ready);

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && !in_window |=> mem_valid);

  assert_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid || mem_valid);
endmodule

bind wt_word_cache wtc_checker #(.WINDOW_BASE(WINDOW_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_size  (mem_size),
  .mem_addr  (mem_addr)
);

// File: tb/sim_wt_word_cache.sv
module sim_wt_word_cache;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, big_endian;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_ready, mem_write;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  wt_word_cache u0 (.*);

  int n_chk = 0, n_fail = 0;
  int mem_lat = 2;
  int hs_cnt = 0;
  logic [31:0] last_addr, last_wdata;
  logic [1:0]  last_size;
  logic [31:0] wmem [logic [31:0]];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] k;
    k = {a[31:2], 2'b00};
    if (wmem.exists(k)) return wmem[k];
    return {k[15:0] ^ 16'h5A3C, k[31:16] ^ 16'h0F0F};
  endfunction

  function automatic logic [31:0] exp_lane(input logic [31:0] w, input logic [31:0] a,
                                           input logic [1:0] sz, input logic be);
    logic [1:0] o;
    o = a[1:0] ^ (be ? 2'b11 : 2'b00);
    if (sz == 2'b00) return (w >> (8 * o)) & 32'hFF;
    if (sz == 2'b01) return (w >> (16 * o[1])) & 32'hFFFF;
    return w;
  endfunction

  function automatic string rname(input int k);
    case (k)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic check_eq(input string rq, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory responder: ready after mem_lat waiting cycles, one-cycle pulse
  initial begin
    int wcnt;
    logic [31:0] w;
    logic [1:0]  o;
    wcnt = 0;
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
        wcnt = 0;
      end else if (mem_valid) begin
        if (wcnt >= mem_lat) begin
          mem_ready  = 1'b1;
          hs_cnt++;
          last_addr  = mem_addr;
          last_size  = mem_size;
          last_wdata = mem_wdata;
          if (mem_write) begin
            w = mem_word(mem_addr);
            o = mem_addr[1:0] ^ {big_endian, big_endian};
            if (mem_size == 2'b00)      w[{o, 3'b000} +: 8]     = mem_wdata[7:0];
            else if (mem_size == 2'b01) w[{o[1], 4'b0000} +: 16] = mem_wdata[15:0];
            else                        w = mem_wdata;
            wmem[{mem_addr[31:2], 2'b00}] = w;
          end else begin
            mem_rdata = mem_word(mem_addr);
          end
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic do_access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                           input logic [31:0] wd, output logic [31:0] rd,
                           output int lat, output int nmem);
    int h0;
    h0 = hs_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    nmem = hs_cnt - h0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        use_mem;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 32'h1000_0040, 32'h0,         1'b1, 4'd4},
    '{1'b0, 2'd2, 32'h1000_0040, 32'h0,         1'b0, 4'd5},
    '{1'b0, 2'd0, 32'h1000_0043, 32'h0,         1'b0, 4'd9},
    '{1'b0, 2'd1, 32'h1000_0042, 32'h0,         1'b0, 4'd9},
    '{1'b0, 2'd0, 32'h1000_0041, 32'h0,         1'b0, 4'd9},
    '{1'b0, 2'd2, 32'h2000_0000, 32'h0,         1'b1, 4'd2},
    '{1'b0, 2'd0, 32'h2000_0001, 32'h0,         1'b1, 4'd2},
    '{1'b0, 2'd2, 32'h1010_0040, 32'h0,         1'b1, 4'd3},
    '{1'b0, 2'd2, 32'h1000_0040, 32'h0,         1'b1, 4'd3},
    '{1'b1, 2'd2, 32'h1000_0080, 32'hDEAD_BEEF, 1'b1, 4'd6},
    '{1'b0, 2'd2, 32'h1000_0080, 32'h0,         1'b0, 4'd7},
    '{1'b1, 2'd0, 32'h1000_0081, 32'h0000_00A7, 1'b1, 4'd6},
    '{1'b0, 2'd2, 32'h1000_0080, 32'h0,         1'b1, 4'd8},
    '{1'b0, 2'd2, 32'h101F_F004, 32'h0,         1'b1, 4'd11},
    '{1'b0, 2'd1, 32'h101F_F006, 32'h0,         1'b0, 4'd11},
    '{1'b0, 2'd2, 32'h0FFF_FFF0, 32'h0,         1'b1, 4'd2},
    '{1'b0, 2'd2, 32'h0FFF_FFF0, 32'h0,         1'b1, 4'd2},
    '{1'b0, 2'd2, 32'h1020_0000, 32'h0,         1'b1, 4'd2},
    '{1'b1, 2'd2, 32'h2000_0010, 32'h1234_5678, 1'b1, 4'd6},
    '{1'b0, 2'd2, 32'h2000_0010, 32'h0,         1'b1, 4'd2},
    '{1'b1, 2'd2, 32'h1000_0100, 32'hCAFE_F00D, 1'b1, 4'd7},
    '{1'b0, 2'd2, 32'h1000_0100, 32'h0,         1'b0, 4'd7},
    '{1'b1, 2'd1, 32'h1000_0100, 32'h0000_BEEF, 1'b1, 4'd6},
    '{1'b0, 2'd2, 32'h1000_0100, 32'h0,         1'b1, 4'd8}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd, first_addr;
    int lat, nmem;
    bit bad_ready, bad_addr;
    rst_n = 1'b0; big_endian = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "req_ready after reset", {31'b0, req_ready}, 32'd1);
    check_eq("R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    check_eq("R1", "mem_valid after reset", {31'b0, mem_valid}, 32'd0);

    // vector table, little-endian lanes
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      do_access(v.wr, v.sz, v.addr, v.wd, rd, lat, nmem);
      check_eq(rname(int'(v.rq)), $sformatf("vec %0d memory use", i), nmem, {31'b0, v.use_mem});
      if (!v.use_mem)
        check_eq(rname(int'(v.rq)), $sformatf("vec %0d hit latency", i), lat, 32'd1);
      if (v.wr) begin
        check_eq("R6", $sformatf("vec %0d mem addr", i), last_addr, v.addr);
        check_eq("R6", $sformatf("vec %0d mem size", i), {30'b0, last_size}, {30'b0, v.sz});
        check_eq("R6", $sformatf("vec %0d mem data", i), last_wdata, v.wd);
      end else begin
        check_eq(rname(int'(v.rq)), $sformatf("vec %0d data", i), rd,
                 exp_lane(mem_word(v.addr), v.addr, v.sz, 1'b0));
        if (v.use_mem)
          check_eq("R4", $sformatf("vec %0d fetch addr", i), last_addr,
                   {v.addr[31:2], 2'b00});
      end
    end

    // R9 fixed values, R10 big-endian lane swap
    do_access(1'b1, 2'd2, 32'h1000_0300, 32'h1122_3344, rd, lat, nmem);
    do_access(1'b0, 2'd0, 32'h1000_0301, 32'h0, rd, lat, nmem);
    check_eq("R9", "byte lane 1 le", rd, 32'h0000_0033);
    check_eq("R7", "byte after word store hits", nmem, 32'd0);
    big_endian = 1'b1;
    do_access(1'b0, 2'd0, 32'h1000_0300, 32'h0, rd, lat, nmem);
    check_eq("R10", "byte offset 0 be", rd, 32'h0000_0011);
    do_access(1'b0, 2'd1, 32'h1000_0302, 32'h0, rd, lat, nmem);
    check_eq("R10", "half offset 2 be", rd, 32'h0000_3344);
    do_access(1'b0, 2'd0, 32'h1000_0303, 32'h0, rd, lat, nmem);
    check_eq("R10", "byte offset 3 be", rd, 32'h0000_0044);
    big_endian = 1'b0;

    // R12 stall with slow memory
    mem_lat = 5;
    bad_ready = 1'b0; bad_addr = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_addr = 32'h1000_0207;
    @(negedge clk);
    req_valid = 1'b0;
    first_addr = mem_addr;
    lat = 1;
    while (!rsp_valid && lat < 100) begin
      if (req_ready) bad_ready = 1'b1;
      if (mem_valid && mem_addr !== first_addr) bad_addr = 1'b1;
      @(negedge clk);
      lat++;
    end
    check_eq("R12", "ready low during miss", {31'b0, bad_ready}, 32'd0);
    check_eq("R12", "mem addr stable", {31'b0, bad_addr}, 32'd0);
    check_eq("R4", "slow fetch aligned addr", first_addr, 32'h1000_0204);
    check_eq("R4", "slow miss response", rd_or(rsp_rdata),
             exp_lane(mem_word(32'h1000_0207), 32'h1000_0207, 2'd0, 1'b0));
    check_eq("R12", "ready back after response", {31'b0, req_ready}, 32'd1);
    mem_lat = 2;

    // R1: reset invalidates lines filled earlier
    do_access(1'b0, 2'd2, 32'h1000_0300, 32'h0, rd, lat, nmem);
    check_eq("R5", "hit before reset", nmem, 32'd0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    do_access(1'b0, 2'd2, 32'h1000_0300, 32'h0, rd, lat, nmem);
    check_eq("R1", "miss after reset", nmem, 32'd1);
    check_eq("R1", "data after reset", rd, 32'h1122_3344);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic [31:0] rd_or(input logic [31:0] x);
    return x;
  endfunction
endmodule